// File: doc/BRIEF.md
# CompactFlash Sector Reader

This block is a hardware sequencer that pulls a fixed run of consecutive sectors from a CompactFlash card and writes them into a local buffer. The card runs in 8-bit IDE register mode. A pulse on `start_i` launches the sequence. The block selects LBA addressing on the master device and enables 8-bit transfers with a set-features command. It then reads each sector with a read-sector command and polls the status register before every data byte. Each byte is pushed through a plain write port (address, data, enable).

All card access goes through an eight-register task-file bus with a 3-bit address, 8-bit data, and separate read and write strobes. Every register access is one bus cycle whose strobe is held for a set number of clocks. Status polls are guarded by a clock-count timeout. An error bit reported by the card, or a poll that never completes, stops the run with `error_o` high. A clean finish is marked by a one-clock `done_o` pulse.

Top module: `cf_sector_reader`

## Requirements
- R1: While `rst_ni` is low and after release, `tf_rd_o`, `tf_wr_o`, `buf_we_o`, `done_o` and `error_o` are 0 until a start pulse arrives.
- R2: The first three task-file writes of a run are, in this order: 0xE0 to address 6 (device/head), 0x01 to address 1 (feature), and 0xEF to address 7 (command).
- R3: A command byte is written to address 7 only after the most recent status read (address 7) showed bit 7 (BUSY) at 0 and bit 6 (READY) at 1.
- R4: For each sector, the block writes 0x01 to address 2, the sector number to address 3, 0xF4 to address 4 and 0x00 to address 5, in that order, and then writes 0x20 to address 7.
- R5: The sector numbers are 0x7C, 0x7D, 0x7E and 0x7F. No read command follows sector 0x7F, so each run makes exactly 23 task-file writes.
- R6: Each read of address 0 (data) comes after a status read with BUSY=0 and bit 3 (DRQ)=1. Exactly 512 data reads are made per sector.
- R7: Every byte read from address 0 is written to the buffer. Buffer addresses start at the base (0) and rise by one per byte across sector boundaries, reaching 2047.
- R8: `done_o` is high for exactly one clock, in the same cycle as the 2048th buffer write, and `error_o` stays 0 on a clean run.
- R9: If a status read after a command shows BUSY=0 and bit 0 (ERR)=1, the block sets `error_o` and makes no further bus access. `error_o` stays high until the next start pulse, which clears it.
- R10: If a status poll has not met its condition within POLL_LIMIT+1 clocks, `error_o` is set and the run stops.
- R11: Each bus access raises exactly one of `tf_rd_o` or `tf_wr_o`, holds it for STROBE_CYCLES clocks, and keeps `tf_addr_o` steady while the strobe is high.
- R12: A start pulse while a run is in progress has no effect on the bus traffic or the buffer writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-clock pulse that launches a run |
| tf_addr_o | output | 3 | Task-file register address |
| tf_wdata_o | output | 8 | Task-file write data |
| tf_rdata_i | input | 8 | Task-file read data |
| tf_rd_o | output | 1 | Task-file read strobe |
| tf_wr_o | output | 1 | Task-file write strobe |
| buf_addr_o | output | BUF_AW | Buffer write address |
| buf_data_o | output | 8 | Buffer write data |
| buf_we_o | output | 1 | Buffer write enable |
| done_o | output | 1 | One-clock pulse on the final buffer write |
| error_o | output | 1 | Run aborted by a card error or a poll timeout |

## Verification
The main read flow is run against a card model in four ways:
- a clean card, which separates correct register order, sector numbering and buffer addressing from off-by-one sector or byte counts;
- a card that reports ERR after set-features, which shows that the error path stops all further access;
- a card whose READY bit comes up late, which shows that commands are gated on READY and not only on BUSY;
- a card stuck busy, which measures when the timeout fires.

The model drops DRQ for two clocks after every data read, so a design that skipped the per-byte DRQ poll would be caught. The model's data pattern depends on both the sector number and the byte index, so swapped or repeated sectors show up in the buffer contents.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int TF_AW = 3;
  localparam int TF_DW = 8;

  localparam logic [TF_AW-1:0] REG_DATA = 3'd0;
  localparam logic [TF_AW-1:0] REG_FEAT = 3'd1;
  localparam logic [TF_AW-1:0] REG_CNT  = 3'd2;
  localparam logic [TF_AW-1:0] REG_LBA0 = 3'd3;
  localparam logic [TF_AW-1:0] REG_LBA1 = 3'd4;
  localparam logic [TF_AW-1:0] REG_LBA2 = 3'd5;
  localparam logic [TF_AW-1:0] REG_DEV  = 3'd6;
  localparam logic [TF_AW-1:0] REG_CMD  = 3'd7;

  localparam int ST_BSY  = 7;
  localparam int ST_RDY  = 6;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  localparam logic [TF_DW-1:0] CMD_SETFEAT = 8'hEF;
  localparam logic [TF_DW-1:0] CMD_RDSEC   = 8'h20;
  localparam logic [TF_DW-1:0] FEAT_8BIT   = 8'h01;
  localparam logic [TF_DW-1:0] DEV_LBA_M   = 8'hE0;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_FEAT, S_RDY_SF, S_CMD_SF, S_WAIT_SF,
    S_CNT, S_LBA0, S_LBA1, S_LBA2, S_RDY_RD, S_CMD_RD, S_DRQ, S_DATA
  } seq_state_e;
endpackage

// File: rtl/cfr_bus_cycle.sv
module cfr_bus_cycle
  import cfr_pkg::*;
#(
  parameter int STROBE_CYCLES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [TF_AW-1:0] addr_i,
  input  logic [TF_DW-1:0] wdata_i,
  output logic             ack_o,
  output logic [TF_DW-1:0] rdata_o,
  output logic [TF_AW-1:0] tf_addr_o,
  output logic [TF_DW-1:0] tf_wdata_o,
  input  logic [TF_DW-1:0] tf_rdata_i,
  output logic             tf_rd_o,
  output logic             tf_wr_o
);
  localparam int CW = $clog2(STROBE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CYCLES - 1);

  logic             active_q, we_q, ack_q;
  logic [CW-1:0]    cnt_q;
  logic [TF_AW-1:0] addr_q;
  logic [TF_DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      we_q     <= 1'b0;
      ack_q    <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      ack_q <= 1'b0;
      if (!active_q) begin
        if (req_i) begin
          active_q <= 1'b1;
          cnt_q    <= '0;
          we_q     <= we_i;
          addr_q   <= addr_i;
          wdata_q  <= wdata_i;
        end
      end else if (cnt_q == LAST) begin
        active_q <= 1'b0;
        ack_q    <= 1'b1;
        rdata_q  <= tf_rdata_i;  // sample at end of strobe
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tf_rd_o    = active_q & ~we_q;
  assign tf_wr_o    = active_q & we_q;
  assign tf_addr_o  = addr_q;
  assign tf_wdata_o = wdata_q;
  assign ack_o      = ack_q;
  assign rdata_o    = rdata_q;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tf_rd_o && tf_wr_o)); // R11
  AST_ADDR_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tf_rd_o || tf_wr_o) && $past(tf_rd_o || tf_wr_o)) |-> $stable(tf_addr_o)); // R11
endmodule

// File: rtl/cfr_poll_timer.sv
module cfr_poll_timer #(
  parameter int POLL_LIMIT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(POLL_LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LIM);

  AST_TIMER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM); // R10
endmodule

// File: rtl/cfr_seq.sv
module cfr_seq
  import cfr_pkg::*;
#(
  parameter int          SECTOR_BYTES = 512,
  parameter logic [7:0]  FIRST_SECTOR = 8'h7C,
  parameter logic [7:0]  END_SECTOR   = 8'h80,
  parameter logic [7:0]  LBA_MID      = 8'hF4,
  parameter logic [7:0]  LBA_HIGH     = 8'h00,
  parameter int          BUF_AW       = 11,
  parameter logic [BUF_AW-1:0] BUF_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [TF_AW-1:0]  bus_addr_o,
  output logic [TF_DW-1:0]  bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [TF_DW-1:0]  bus_rdata_i,
  output logic              poll_run_o,
  input  logic              poll_expired_i,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [TF_DW-1:0]  buf_data_o,
  output logic              buf_we_o,
  output logic              done_o,
  output logic              error_o
);
  localparam int BCW = $clog2(SECTOR_BYTES);
  localparam logic [BCW-1:0] LAST_BYTE = BCW'(SECTOR_BYTES - 1);

  seq_state_e        state_q;
  logic              pend_q;
  logic [7:0]        sector_q;
  logic [BCW-1:0]    byte_cnt_q;
  logic [BUF_AW-1:0] ptr_q, buf_addr_q;
  logic [TF_DW-1:0]  buf_data_q;
  logic              buf_we_q, done_q, error_q;

  logic st_bsy, st_rdy, st_drq, st_err, st_ready;
  assign st_bsy   = bus_rdata_i[ST_BSY];
  assign st_rdy   = bus_rdata_i[ST_RDY];
  assign st_drq   = bus_rdata_i[ST_DRQ];
  assign st_err   = bus_rdata_i[ST_ERR];
  assign st_ready = !st_bsy && st_rdy;

  always_comb begin
    bus_we_o    = 1'b0;
    bus_addr_o  = REG_CMD;
    bus_wdata_o = '0;
    unique case (state_q)
      S_DEV:    begin bus_we_o = 1'b1; bus_addr_o = REG_DEV;  bus_wdata_o = DEV_LBA_M;   end
      S_FEAT:   begin bus_we_o = 1'b1; bus_addr_o = REG_FEAT; bus_wdata_o = FEAT_8BIT;   end
      S_CMD_SF: begin bus_we_o = 1'b1; bus_addr_o = REG_CMD;  bus_wdata_o = CMD_SETFEAT; end
      S_CNT:    begin bus_we_o = 1'b1; bus_addr_o = REG_CNT;  bus_wdata_o = 8'h01;       end
      S_LBA0:   begin bus_we_o = 1'b1; bus_addr_o = REG_LBA0; bus_wdata_o = sector_q;    end
      S_LBA1:   begin bus_we_o = 1'b1; bus_addr_o = REG_LBA1; bus_wdata_o = LBA_MID;     end
      S_LBA2:   begin bus_we_o = 1'b1; bus_addr_o = REG_LBA2; bus_wdata_o = LBA_HIGH;    end
      S_CMD_RD: begin bus_we_o = 1'b1; bus_addr_o = REG_CMD;  bus_wdata_o = CMD_RDSEC;   end
      S_DATA:   begin bus_addr_o = REG_DATA; end
      default:  ;
    endcase
  end

  assign bus_req_o  = (state_q != S_IDLE) && !pend_q;
  assign poll_run_o = (state_q == S_RDY_SF) || (state_q == S_WAIT_SF) ||
                      (state_q == S_RDY_RD) || (state_q == S_DRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      pend_q     <= 1'b0;
      sector_q   <= FIRST_SECTOR;
      byte_cnt_q <= '0;
      ptr_q      <= BUF_BASE;
      buf_addr_q <= '0;
      buf_data_q <= '0;
      buf_we_q   <= 1'b0;
      done_q     <= 1'b0;
      error_q    <= 1'b0;
    end else begin
      buf_we_q <= 1'b0;
      done_q   <= 1'b0;
      if (state_q == S_IDLE) begin
        pend_q <= 1'b0;
        if (start_i) begin
          state_q    <= S_DEV;
          error_q    <= 1'b0;
          sector_q   <= FIRST_SECTOR;
          byte_cnt_q <= '0;
          ptr_q      <= BUF_BASE;
        end
      end else if (poll_run_o && poll_expired_i) begin
        error_q <= 1'b1;
        state_q <= S_IDLE;
        pend_q  <= 1'b0;
      end else if (bus_ack_i) begin
        pend_q <= 1'b0;
        unique case (state_q)
          S_DEV:    state_q <= S_FEAT;
          S_FEAT:   state_q <= S_RDY_SF;
          S_RDY_SF: if (st_ready) state_q <= S_CMD_SF;
          S_CMD_SF: state_q <= S_WAIT_SF;
          S_WAIT_SF:
            if (!st_bsy) begin
              if (st_err) begin error_q <= 1'b1; state_q <= S_IDLE; end
              else state_q <= S_CNT;
            end
          S_CNT:    state_q <= S_LBA0;
          S_LBA0:   state_q <= S_LBA1;
          S_LBA1:   state_q <= S_LBA2;
          S_LBA2:   state_q <= S_RDY_RD;
          S_RDY_RD: if (st_ready) state_q <= S_CMD_RD;
          S_CMD_RD: state_q <= S_DRQ;
          S_DRQ:
            if (!st_bsy) begin
              if (st_err) begin error_q <= 1'b1; state_q <= S_IDLE; end
              else if (st_drq) state_q <= S_DATA;
            end
          S_DATA: begin
            buf_we_q   <= 1'b1;
            buf_data_q <= bus_rdata_i;
            buf_addr_q <= ptr_q;
            ptr_q      <= ptr_q + 1'b1;
            if (byte_cnt_q == LAST_BYTE) begin
              byte_cnt_q <= '0;
              if (sector_q + 8'd1 == END_SECTOR) begin
                done_q  <= 1'b1;
                state_q <= S_IDLE;
              end else begin
                sector_q <= sector_q + 8'd1;
                state_q  <= S_CNT;
              end
            end else begin
              byte_cnt_q <= byte_cnt_q + 1'b1;
              state_q    <= S_DRQ;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end else if (bus_req_o) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign buf_addr_o = buf_addr_q;
  assign buf_data_o = buf_data_q;
  assign buf_we_o   = buf_we_q;
  assign done_o     = done_q;
  assign error_o    = error_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_TIMEOUT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_run_o && poll_expired_i) |=> error_o); // R10
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> !bus_req_o); // R9
  AST_NO_START_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != S_IDLE && state_q != S_DATA) |=> (state_q != S_DEV)); // R12
endmodule

// File: rtl/cf_sector_reader.sv
module cf_sector_reader
  import cfr_pkg::*;
#(
  parameter int          STROBE_CYCLES = 2,
  parameter int          POLL_LIMIT    = 100000,
  parameter int          SECTOR_BYTES  = 512,
  parameter logic [7:0]  FIRST_SECTOR  = 8'h7C,
  parameter logic [7:0]  END_SECTOR    = 8'h80,
  parameter logic [7:0]  LBA_MID       = 8'hF4,
  parameter logic [7:0]  LBA_HIGH      = 8'h00,
  parameter int          BUF_AW        = 11,
  parameter logic [BUF_AW-1:0] BUF_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [2:0]        tf_addr_o,
  output logic [7:0]        tf_wdata_o,
  input  logic [7:0]        tf_rdata_i,
  output logic              tf_rd_o,
  output logic              tf_wr_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              buf_we_o,
  output logic              done_o,
  output logic              error_o
);
  logic             bus_req, bus_we, bus_ack;
  logic [TF_AW-1:0] bus_addr;
  logic [TF_DW-1:0] bus_wdata, bus_rdata;
  logic             poll_run, poll_expired;

  cfr_seq #(
    .SECTOR_BYTES(SECTOR_BYTES), .FIRST_SECTOR(FIRST_SECTOR), .END_SECTOR(END_SECTOR),
    .LBA_MID(LBA_MID), .LBA_HIGH(LBA_HIGH), .BUF_AW(BUF_AW), .BUF_BASE(BUF_BASE)
  ) u_seq (
    .clk_i, .rst_ni, .start_i,
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .poll_run_o(poll_run), .poll_expired_i(poll_expired),
    .buf_addr_o, .buf_data_o, .buf_we_o, .done_o, .error_o
  );

  cfr_bus_cycle #(.STROBE_CYCLES(STROBE_CYCLES)) u_bus (
    .clk_i, .rst_ni,
    .req_i(bus_req), .we_i(bus_we), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .ack_o(bus_ack), .rdata_o(bus_rdata),
    .tf_addr_o, .tf_wdata_o, .tf_rdata_i, .tf_rd_o, .tf_wr_o
  );

  cfr_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk_i, .rst_ni, .run_i(poll_run), .expired_o(poll_expired)
  );
endmodule

// File: tb/sim_cf_sector_reader.sv
module sim_cf_sector_reader;
  localparam int CLK_PERIOD = 10;
  localparam int STROBE     = 3;
  localparam int POLL_LIM   = 400;
  localparam int SEC_BYTES  = 512;
  localparam int TOTAL      = 2048;
  localparam int BUSY_T     = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  tf_addr;
  logic [7:0]  tf_wdata, tf_rdata;
  logic        tf_rd, tf_wr;
  logic [10:0] buf_addr;
  logic [7:0]  buf_data;
  logic        buf_we, done, error;

  always #(CLK_PERIOD/2) clk = ~clk;

  cf_sector_reader #(.STROBE_CYCLES(STROBE), .POLL_LIMIT(POLL_LIM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .tf_addr_o(tf_addr), .tf_wdata_o(tf_wdata), .tf_rdata_i(tf_rdata),
    .tf_rd_o(tf_rd), .tf_wr_o(tf_wr),
    .buf_addr_o(buf_addr), .buf_data_o(buf_data), .buf_we_o(buf_we),
    .done_o(done), .error_o(error)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 7 + i * 3 + i / 256) & 255);
  endfunction

  // card model
  int   m_busy_cnt, m_drdy_hold, m_bytes_left, m_gap, m_idx, m_sector;
  bit   m_stuck, m_err, m_drq, m_err_sf;
  bit   rd_d, wr_d;
  logic [2:0] addr_d;
  logic [7:0] data_d;
  int   sw, strobe_bad, viol_cmd, viol_drq, m_acc;
  logic [2:0] log_a [0:63];
  logic [7:0] log_d [0:63];
  int   log_n;

  wire m_busy = m_stuck || (m_busy_cnt > 0);
  wire m_drdy = (m_drdy_hold == 0);
  assign tf_rdata = (tf_addr == 3'd7) ? {m_busy, m_drdy, 2'b00, m_drq, 2'b00, m_err}
                                      : pat(m_sector, m_idx);

  always @(negedge clk) begin
    if (m_busy_cnt > 0) m_busy_cnt--;
    if (m_drdy_hold > 0) m_drdy_hold--;
    if (tf_rd && tf_wr) strobe_bad++;
    if (tf_rd || tf_wr) sw++;
    else if (sw != 0) begin
      if (sw != STROBE) strobe_bad++;
      sw = 0;
    end
    if ((tf_rd && !rd_d) || (tf_wr && !wr_d)) m_acc++;
    if (tf_rd && !rd_d && tf_addr == 3'd0 && (!m_drq || m_busy)) viol_drq++;
    if (wr_d && !tf_wr) begin
      if (log_n < 64) begin log_a[log_n] = addr_d; log_d[log_n] = data_d; end
      log_n++;
      if (addr_d == 3'd3) m_sector = int'(data_d);
      if (addr_d == 3'd7) begin
        if (m_stuck || m_busy_cnt > 0 || m_drdy_hold > 0) viol_cmd++;
        m_busy_cnt = BUSY_T;
        if (data_d == 8'hEF) m_err = m_err_sf;
        if (data_d == 8'h20) begin
          m_err = 1'b0; m_bytes_left = SEC_BYTES; m_idx = 0; m_drq = 1'b0;
        end
      end
    end
    if (rd_d && !tf_rd && addr_d == 3'd0) begin
      m_idx++; m_bytes_left--; m_drq = 1'b0; m_gap = 2;
    end else if (m_gap > 0) m_gap--;
    else if (!m_stuck && m_busy_cnt == 0 && m_bytes_left > 0) m_drq = 1'b1;
    rd_d = tf_rd; wr_d = tf_wr; addr_d = tf_addr; data_d = tf_wdata;
  end

  // buffer / done monitor
  int we_n, addr_bad, data_bad, done_n, done_bad;
  bit done_prev;
  always @(negedge clk) begin
    if (buf_we) begin
      if (int'(buf_addr) != we_n) addr_bad++;
      if (buf_data != pat(8'h7C + we_n / SEC_BYTES, we_n % SEC_BYTES)) data_bad++;
      we_n++;
    end
    if (done) begin
      done_n++;
      if (!buf_we || we_n != TOTAL) done_bad++;
      if (done_prev) done_bad++;
    end
    done_prev = done;
  end

  task automatic model_reset(input bit err_sf, input bit stuck, input int drdy_hold);
    m_busy_cnt = 0; m_drdy_hold = drdy_hold; m_bytes_left = 0; m_gap = 0; m_idx = 0;
    m_sector = 0; m_stuck = stuck; m_err = 1'b0; m_drq = 1'b0; m_err_sf = err_sf;
    sw = 0; strobe_bad = 0; viol_cmd = 0; viol_drq = 0; m_acc = 0; log_n = 0;
    we_n = 0; addr_bad = 0; data_bad = 0; done_n = 0; done_bad = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done_n > 0 || error) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_log();
    int bad_init = 0, bad_sec = 0, bad_num = 0;
    chk(log_n == 23, "R5", "task-file write count", log_n, 23);
    if (log_n == 23) begin
      if (log_a[0] != 3'd6 || log_d[0] != 8'hE0) bad_init++;
      if (log_a[1] != 3'd1 || log_d[1] != 8'h01) bad_init++;
      if (log_a[2] != 3'd7 || log_d[2] != 8'hEF) bad_init++;
      for (int s = 0; s < 4; s++) begin
        int b = 3 + 5 * s;
        if (log_a[b] != 3'd2 || log_d[b] != 8'h01) bad_sec++;
        if (log_a[b+1] != 3'd3) bad_sec++;
        if (log_d[b+1] != 8'(8'h7C + s)) bad_num++;
        if (log_a[b+2] != 3'd4 || log_d[b+2] != 8'hF4) bad_sec++;
        if (log_a[b+3] != 3'd5 || log_d[b+3] != 8'h00) bad_sec++;
        if (log_a[b+4] != 3'd7 || log_d[b+4] != 8'h20) bad_sec++;
      end
    end
    chk(bad_init == 0, "R2", "init write mismatches", bad_init, 0);
    chk(bad_sec == 0, "R4", "sector setup mismatches", bad_sec, 0);
    chk(bad_num == 0, "R5", "sector number mismatches", bad_num, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({tf_rd, tf_wr, buf_we, done, error} == 5'b0, "R1", "outputs in reset",
        int'({tf_rd, tf_wr, buf_we, done, error}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({tf_rd, tf_wr, buf_we, done, error} == 5'b0, "R1", "outputs after release",
        int'({tf_rd, tf_wr, buf_we, done, error}), 0);
  endtask

  task automatic t_clean_run();
    model_reset(1'b0, 1'b0, 0);
    pulse_start();
    for (int i = 0; i < 60000 && we_n < 700; i++) @(negedge clk);
    pulse_start();  // R12: ignored mid-run
    wait_end(80000);
    check_log();
    chk(log_n == 23, "R12", "writes after mid-run start", log_n, 23);
    chk(we_n == TOTAL, "R6", "buffer writes", we_n, TOTAL);
    chk(viol_drq == 0, "R6", "data reads without DRQ", viol_drq, 0);
    chk(viol_cmd == 0, "R3", "commands while not ready", viol_cmd, 0);
    chk(addr_bad == 0, "R7", "address mismatches", addr_bad, 0);
    chk(data_bad == 0, "R7", "data mismatches", data_bad, 0);
    chk(done_n == 1, "R8", "done pulses", done_n, 1);
    chk(done_bad == 0, "R8", "done timing faults", done_bad, 0);
    chk(error == 1'b0, "R8", "error on clean run", int'(error), 0);
    chk(strobe_bad == 0, "R11", "strobe faults", strobe_bad, 0);
  endtask

  task automatic t_setfeat_err();
    int acc0;
    model_reset(1'b1, 1'b0, 0);
    pulse_start();
    wait_end(5000);
    chk(error == 1'b1, "R9", "error after ERR", int'(error), 1);
    chk(log_n == 3, "R9", "writes before stop", log_n, 3);
    chk(we_n == 0 && done_n == 0, "R9", "buffer writes or done", we_n + done_n, 0);
    acc0 = m_acc;
    repeat (50) @(negedge clk);
    chk(m_acc == acc0, "R9", "bus accesses after error", m_acc - acc0, 0);
    chk(error == 1'b1, "R9", "error held", int'(error), 1);
  endtask

  task automatic t_late_ready();
    model_reset(1'b0, 1'b0, 150);
    pulse_start();
    repeat (2) @(negedge clk);
    chk(error == 1'b0, "R9", "error cleared by start", int'(error), 0);
    wait_end(80000);
    chk(viol_cmd == 0, "R3", "command before READY", viol_cmd, 0);
    chk(done_n == 1 && error == 1'b0, "R3", "late-ready run completion", done_n, 1);
    chk(data_bad == 0 && we_n == TOTAL, "R7", "late-ready buffer", we_n, TOTAL);
  endtask

  task automatic t_timeout();
    int cyc = 0;
    model_reset(1'b0, 1'b1, 0);
    pulse_start();
    for (int i = 0; i < 3000 && !error; i++) begin @(negedge clk); cyc++; end
    chk(error == 1'b1, "R10", "error on stuck busy", int'(error), 1);
    chk(cyc >= POLL_LIM && cyc <= POLL_LIM + 60, "R10", "cycles to timeout", cyc, POLL_LIM + 13);
    chk(log_n == 2, "R10", "writes before timeout", log_n, 2);
    m_stuck = 1'b0;
  endtask

  initial begin
    t_reset();
    t_clean_run();
    t_setfeat_err();
    t_late_ready();
    t_timeout();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule